// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This block collects interrupt causes for a simple network controller and drives one level-sensitive interrupt line to the host. Single-cycle event pulses from the command unit, receive unit, management interface and flow-control logic set sticky bits in an 8-bit cause register. The host reads that register and retires causes by writing ones to them.

A second 8-bit control byte holds three things. Bit 0 is a global disable. Bit 1 is a self-clearing trigger that raises a software interrupt. Bits 2 to 7 are per-cause masks. The mask positions do not line up with the cause positions they gate, so the block realigns them before combining them with the causes. The software cause and the management cause have no mask bit and are gated only by the global disable.

Both registers sit in a small register window behind a plain read/write port. The offsets are parameters, with defaults at 1 for the cause byte and 3 for the control byte.

Top module: `nic_irq_unit`

## Requirements
- R1: After reset the cause byte reads 0x00, the control byte reads 0x01 (global disable set, all masks clear) and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets cause bit k on the next clock edge for every k except 2, and the bit stays set until it is cleared. Cause bits are: 0 pause frame seen, 1 early receive, 2 software, 3 management access done, 4 receiver out of resources, 5 command unit left active, 6 frame received, 7 command done. The cause byte is read at offset `STAT_OFS` (default 1).
- R3: Writing the cause byte clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event pulse and a write-one-to-clear hit the same cause bit in the same cycle, the bit ends up set.
- R5: The control byte is written and read at offset `CTRL_OFS` (default 3). It reads back as written, except that bit 1 always reads 0.
- R6: Writing the control byte with bit 1 set makes cause bit 2 read 1 after the second clock edge that follows the write.
- R7: While control bit 0 is 1, `irq_o` is low whatever the cause and mask bits hold.
- R8: Control bits 2, 3, 4, 5, 6 and 7 mask cause bits 0, 1, 4, 5, 6 and 7 respectively. A set mask bit keeps its cause from raising `irq_o`, but the cause bit still reads as set.
- R9: With control bit 0 clear, cause bits 2 and 3 raise `irq_o` no matter how bits 2 to 7 of the control byte are set.
- R10: `evt_i[2]` has no effect: cause bit 2 is set only through control bit 1.
- R11: Reads at any offset other than the two register offsets return 0x00, and writes there change neither register.
- R12: With the default combinational output (`IRQ_REG` = 0), `irq_o` is high in the same cycle as a cause bit that is set, unmasked and not globally disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register offset for the read and write port |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_i | input | 8 | Event pulses, one per cause bit (bit 2 unused) |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its defaults: a 3-bit offset space, the cause byte at 1, the control byte at 3 and a combinational interrupt output. With the 3-bit space, the unused offsets 0, 2 and 4 to 7 are all reachable. Random writes then land on both registers and on dead offsets at similar rates. Because `irq_o` is unregistered in this build, every cycle's interrupt level can be compared directly with the cause and mask state that the bench model predicts for that cycle.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
   localparam int NBITS = 8;

   // cause bit positions
   localparam int B_PAUSE = 0;
   localparam int B_ERLY  = 1;
   localparam int B_SOFT  = 2;
   localparam int B_MGMT  = 3;
   localparam int B_NORES = 4;
   localparam int B_CUIDL = 5;
   localparam int B_FRAME = 6;
   localparam int B_CDONE = 7;

   // control bit positions
   localparam int C_GDIS = 0;
   localparam int C_SOFT = 1;
   localparam int C_MLO  = 2;

   typedef logic [NBITS-1:0] irq_vec_t;
   typedef logic [NBITS-C_MLO-1:0] mask_fld_t;

   // Move the six mask bits onto the cause positions they gate.
   function automatic irq_vec_t align_mask(mask_fld_t m);
      irq_vec_t r;
      r          = '0;
      r[B_PAUSE] = m[0];
      r[B_ERLY]  = m[1];
      r[B_NORES] = m[2];
      r[B_CUIDL] = m[3];
      r[B_FRAME] = m[4];
      r[B_CDONE] = m[5];
      return r;
   endfunction
endpackage

// File: rtl/nic_irq_status.sv
module nic_irq_status
   import nic_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  irq_vec_t set_i,
   input  irq_vec_t clr_i,
   output irq_vec_t stat_o
);
   irq_vec_t stat_q;

   genvar gi;
   generate
      for (gi = 0; gi < NBITS; gi++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               stat_q[gi] <= 1'b0;
            else if (set_i[gi])
               stat_q[gi] <= 1'b1;
            else if (clr_i[gi])
               stat_q[gi] <= 1'b0;
         end
      end
   endgenerate

   assign stat_o = stat_q;
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
   import nic_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_i,
   input  irq_vec_t wdata_i,
   output irq_vec_t ctrl_o,
   output logic     soft_o
);
   irq_vec_t ctrl_q;
   logic     soft_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q         <= '0;
         ctrl_q[C_GDIS] <= 1'b1;
         soft_q         <= 1'b0;
      end else begin
         soft_q <= wr_i & wdata_i[C_SOFT];
         if (wr_i) begin
            ctrl_q         <= wdata_i;
            ctrl_q[C_SOFT] <= 1'b0;
         end
      end
   end

   assign ctrl_o = ctrl_q;
   assign soft_o = soft_q;
endmodule

// File: rtl/nic_irq_gate.sv
module nic_irq_gate
   import nic_irq_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
)(
   input  logic      clk,
   input  logic      rst_n,
   input  irq_vec_t  stat_i,
   input  mask_fld_t mask_i,
   input  logic      gdis_i,
   output logic      irq_o
);
   irq_vec_t live;
   logic     irq_d;

   assign live  = stat_i & ~align_mask(mask_i);
   assign irq_d = ~gdis_i & (|live);

   generate
      if (IRQ_REG) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_d;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign irq_o = irq_d;
      end
   endgenerate
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
   import nic_irq_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int STAT_OFS = 1,
   parameter int CTRL_OFS = 3,
   parameter bit IRQ_REG  = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [7:0]        evt_i,
   output logic              irq_o
);
   localparam int SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_w
         $error("nic_irq_unit: ADDR_W out of range");
      end
      if (STAT_OFS >= SPAN || CTRL_OFS >= SPAN) begin : g_bad_ofs
         $error("nic_irq_unit: offset beyond address space");
      end
      if (STAT_OFS == CTRL_OFS) begin : g_clash
         $error("nic_irq_unit: register offsets collide");
      end
   endgenerate

   irq_vec_t stat_q, ctrl_q, set_v, clr_v;
   logic     soft_p;
   logic     hit_stat, hit_ctrl;

   assign hit_stat = (reg_addr == A_STAT);
   assign hit_ctrl = (reg_addr == A_CTRL);

   always_comb begin
      set_v         = evt_i;
      set_v[B_SOFT] = soft_p;
      clr_v         = (reg_wr && hit_stat) ? reg_wdata : '0;
   end

   nic_irq_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .stat_o (stat_q)
   );

   nic_irq_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr && hit_ctrl),
      .wdata_i (reg_wdata),
      .ctrl_o  (ctrl_q),
      .soft_o  (soft_p)
   );

   nic_irq_gate #(.IRQ_REG(IRQ_REG)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat_q),
      .mask_i (ctrl_q[NBITS-1:C_MLO]),
      .gdis_i (ctrl_q[C_GDIS]),
      .irq_o  (irq_o)
   );

   always_comb begin
      if (hit_stat)      reg_rdata = stat_q;
      else if (hit_ctrl) reg_rdata = ctrl_q;
      else               reg_rdata = '0;
   end
endmodule

// File: rtl/nic_irq_chk.sv
module nic_irq_chk #(
   parameter int ADDR_W   = 3,
   parameter int STAT_OFS = 1,
   parameter int CTRL_OFS = 3,
   parameter bit IRQ_REG  = 1'b0
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        evt_i,
   input logic [7:0]        stat_q,
   input logic [7:0]        ctrl_q,
   input logic              irq_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

   logic wr_stat, wr_ctrl;
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

   // R2: set cause bits persist when no clear is written
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R2 / R4: events (bit 2 excluded) are visible after the edge, clear or not
   p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & 8'hFB)) |=> ((stat_q & $past(evt_i & 8'hFB)) == $past(evt_i & 8'hFB)));

   // R3: bits written as one with no event are gone after the edge
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !(|(evt_i & reg_wdata & 8'hFB))) |=>
         ((stat_q & $past(reg_wdata & 8'hFB)) == 8'h00));

   // R6: software trigger shows up in cause bit 2 two edges later
   p_soft_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata[1]) |=> ##1 stat_q[2]);

   // R5: the trigger bit never holds in the control register
   p_trig_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> !ctrl_q[1]);

   generate
      if (IRQ_REG) begin : g_areg
         // R7: registered output follows the disable one edge late
         p_gdis_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_q[0] |=> !irq_o);
      end else begin : g_acomb
         // R7
         p_gdis_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_q[0] |-> !irq_o);
         // R9: unmaskable causes raise the line when enabled
         p_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_q[0] && (stat_q[2] || stat_q[3])) |-> irq_o);
      end
   endgenerate
endmodule

bind nic_irq_unit nic_irq_chk #(
   .ADDR_W   (ADDR_W),
   .STAT_OFS (STAT_OFS),
   .CTRL_OFS (CTRL_OFS),
   .IRQ_REG  (IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .evt_i     (evt_i),
   .stat_q    (stat_q),
   .ctrl_q    (ctrl_q),
   .irq_o     (irq_o)
);

// File: tb/nic_irq_unit_bench.sv
module nic_irq_unit_bench;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic [7:0]    evt_i = '0;
   logic          irq_o;

   int n_run = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   nic_irq_unit u_nic_irq_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_i     (evt_i),
      .irq_o     (irq_o)
   );

   // reference state built from the requirements
   logic [7:0] m_stat, m_ctrl;
   logic       m_soft;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stat <= 8'h00;
         m_ctrl <= 8'h01;
         m_soft <= 1'b0;
      end else begin
         m_stat <= (m_stat & ~((reg_wr && reg_addr == 3'd1) ? reg_wdata : 8'h00))
                   | (evt_i & 8'hFB) | {5'd0, m_soft, 2'd0};
         m_soft <= reg_wr && reg_addr == 3'd3 && reg_wdata[1];
         if (reg_wr && reg_addr == 3'd3) m_ctrl <= reg_wdata & 8'hFD;
      end
   end

   function automatic logic [7:0] exp_read(logic [AW-1:0] a);
      if (a == 3'd1) return m_stat;
      if (a == 3'd3) return m_ctrl;
      return 8'h00;
   endfunction

   function automatic logic exp_irq(logic [7:0] s, logic [7:0] c);
      logic [7:0] mk;
      mk = {c[7], c[6], c[5], c[4], 1'b0, 1'b0, c[3], c[2]};
      return !c[0] && |(s & ~mk);
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   // drive one cycle of stimulus, check the current read and interrupt level
   task automatic step(input logic [AW-1:0] a, input logic w, input logic [7:0] d,
                       input logic [7:0] e, input string tag);
      @(negedge clk);
      reg_addr = a; reg_wr = w; reg_wdata = d; evt_i = e;
      #1;
      chk(reg_rdata, exp_read(a), {tag, " rdata"});
      chk({7'd0, irq_o}, {7'd0, exp_irq(m_stat, m_ctrl)}, {tag, " irq"});
   endtask

   task automatic idle_read(input logic [AW-1:0] a, input string tag);
      step(a, 1'b0, 8'h00, 8'h00, tag);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state, literal values
      #1;
      reg_addr = 3'd1; #1; chk(reg_rdata, 8'h00, "R1 status");
      reg_addr = 3'd3; #1; chk(reg_rdata, 8'h01, "R1 control");
      chk({7'd0, irq_o}, 8'h00, "R1 irq");

      // R5 enable everything
      step(3'd3, 1'b1, 8'h00, 8'h00, "R5 write ctrl");
      idle_read(3'd3, "R5 ctrl read");
      // R2 events set sticky bits
      step(3'd1, 1'b0, 8'h00, 8'h41, "R2 pulse");
      idle_read(3'd1, "R2 sticky");
      chk(reg_rdata, 8'h41, "R2 status literal");
      chk({7'd0, irq_o}, 8'h01, "R12 irq same cycle");
      // R3 write one to clear bit 0 only
      step(3'd1, 1'b1, 8'h01, 8'h00, "R3 clear");
      idle_read(3'd1, "R3 after");
      chk(reg_rdata, 8'h40, "R3 literal");
      // R4 event beats clear
      step(3'd1, 1'b1, 8'h40, 8'h40, "R4 collide");
      idle_read(3'd1, "R4 after");
      chk(reg_rdata, 8'h40, "R4 literal");
      // R8 masks
      step(3'd3, 1'b1, 8'h40, 8'h00, "R8 mask frame");
      idle_read(3'd1, "R8 masked");
      chk({7'd0, irq_o}, 8'h00, "R8 irq masked");
      step(3'd3, 1'b1, 8'hFC, 8'hF3, "R8 all masks");
      idle_read(3'd1, "R8 all masked");
      chk(reg_rdata, 8'hF3, "R8 bits still read");
      chk({7'd0, irq_o}, 8'h00, "R8 irq all masked");
      // R9 management cause is unmaskable
      step(3'd1, 1'b0, 8'h00, 8'h08, "R9 mgmt");
      idle_read(3'd1, "R9 after");
      chk({7'd0, irq_o}, 8'h01, "R9 irq literal");
      // R7 global disable
      step(3'd3, 1'b1, 8'hFD, 8'h00, "R7 disable");
      idle_read(3'd1, "R7 after");
      chk({7'd0, irq_o}, 8'h00, "R7 irq literal");
      // R6 software trigger, R5 bit1 reads 0
      step(3'd1, 1'b1, 8'hFF, 8'h00, "R6 clear all");
      step(3'd3, 1'b1, 8'hFE, 8'h00, "R6 trigger");
      idle_read(3'd3, "R5 readback");
      chk(reg_rdata, 8'hFC, "R5 bit1 zero");
      idle_read(3'd1, "R6 status");
      chk(reg_rdata, 8'h04, "R6 literal");
      chk({7'd0, irq_o}, 8'h01, "R6 irq");
      // R10 evt bit 2 ignored
      step(3'd1, 1'b1, 8'h04, 8'h00, "R10 clear");
      step(3'd1, 1'b0, 8'h00, 8'h04, "R10 pulse");
      idle_read(3'd1, "R10 after");
      chk(reg_rdata, 8'h00, "R10 literal");
      // R11 dead offsets
      step(3'd0, 1'b1, 8'hFF, 8'h00, "R11 write 0");
      step(3'd2, 1'b1, 8'hFF, 8'h00, "R11 write 2");
      idle_read(3'd5, "R11 read 5");
      idle_read(3'd1, "R11 status kept");
      idle_read(3'd3, "R11 ctrl kept");
      chk(reg_rdata, 8'hFC, "R11 ctrl literal");

      // random mix against the model, covering R2..R12
      for (int i = 0; i < 600; i++) begin
         logic [AW-1:0] a;
         logic [7:0]    e;
         a = AW'($urandom_range(0, 7));
         if ($urandom_range(0, 1) == 1) a = ($urandom_range(0, 1) == 1) ? 3'd1 : 3'd3;
         e = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
         step(a, ($urandom_range(0, 2) == 0), 8'($urandom), e, "R12 random");
      end

      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule